// File: doc/BRIEF.md
# Multi-Polynomial CRC Engine

This block computes CRC checksums for a processor or a DMA master that drives it through a small register window. A 2-bit mode field picks one of four polynomials: CRC-8, CRC-16, CCITT-16 or CRC-32. A seed sets the starting state, so a checksum can pick up from an earlier partial result. Each write to the data register feeds either one byte or one 32-bit word into the calculation. A length bit in the configuration register chooses between the two, and software may change it between writes of the same message. Two option bits reflect the input bytes and the returned checksum. The engine never applies a final XOR: software reads the raw state and applies any XOR-out value itself.

Writes use a valid/ready handshake. Reads are combinational from a separate read address. The datapath handles one byte per clock cycle, so a word takes four cycles. `wr_ready` stays low until the update has finished, which means a checksum read taken after any accepted write already holds the updated value.

The sequencer has two states. `ST_IDLE` waits with ready high. `ST_SHIFT` feeds one byte lane per cycle into the CRC state. The transitions are:
- **start**: `ST_IDLE` → `ST_SHIFT` on an accepted write to the data register.
- **next lane**: `ST_SHIFT` → `ST_SHIFT` while byte lanes remain.
- **done**: `ST_SHIFT` → `ST_IDLE` after the last lane.

Top module: `mpcrc_core`

## Requirements
- R1: After reset, reads of configuration (address 0), seed (address 1) and checksum (address 3) return 0, and `wr_ready` is high.
- R2: Configuration bits [1:0] select the polynomial: 0 = CRC-8 (0x07), 1 = CRC-16 (0x8005), 2 = CCITT (0x1021), 3 = CRC-32 (0x04C11DB7). The update is MSB-first on non-reflected data, and reads of the data address (2) return 0.
- R3: A write to configuration with bit 5 set copies the low N bits of the seed register into the CRC state, where N is the width of the newly written mode. Writing a previously read checksum back as the seed continues that message.
- R4: Configuration bit 4 = 0 makes a data write contribute `wr_data[7:0]`. Bit 4 = 1 makes it contribute all four bytes, least significant byte first, giving the same result as four single-byte writes. The bit may change between writes.
- R5: After an accepted data write, `wr_ready` stays low for 1 cycle for a byte write and 4 cycles for a word write. It then returns high with the checksum fully updated.
- R6: Configuration bit 2 bit-reflects each input byte before it enters the CRC.
- R7: Configuration bit 3 bit-reflects the low N bits of the checksum as read.
- R8: For CRC-8 and the 16-bit modes, checksum bits above N read as 0.
- R9: Writes to the checksum address have no effect. A configuration write with bit 5 clear leaves the CRC state unchanged.
- R10: The checksum read is the raw CRC state, with no final XOR applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the whole block |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | High when a write can be accepted |
| wr_addr | input | 2 | Write register address: 0 config, 1 seed, 2 data, 3 checksum |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 32 | Read data for `rd_addr` |

## Verification
The hardest case to reach from the ports is one message that mixes word writes and byte writes with reflection enabled. In that case the byte order inside a word and the per-byte reflection must agree exactly with a byte-only stream. The stimulus sends a nine-byte message as two little-endian words followed by one byte, and compares the result against a known CRC-32 constant. While doing so it counts the cycles that ready stays low for each write width. A second hard case is continuation from a partial result. The bench reads the checksum mid-message, loads it back as the seed, finishes the message, and expects the same value as an uninterrupted run.

// File: rtl/mpcrc_pkg.sv
package mpcrc_pkg;

    localparam int unsigned CRC_REG_W  = 32;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned LANES      = CRC_REG_W / BYTE_W;
    localparam int unsigned LANE_IDX_W = $clog2(LANES);
    localparam int unsigned ADDR_W     = 2;
    localparam int unsigned CFG_W      = 6;
    localparam int unsigned CFG_LOAD_BIT = 5;

    typedef logic [CRC_REG_W-1:0] word_t;
    typedef logic [BYTE_W-1:0]    byte_t;

    typedef enum logic [1:0] {
        MODE_CRC8  = 2'd0,
        MODE_CRC16 = 2'd1,
        MODE_CCITT = 2'd2,
        MODE_CRC32 = 2'd3
    } crc_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_CFG  = 2'd0,
        REG_SEED = 2'd1,
        REG_DATA = 2'd2,
        REG_SUM  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic      wide;
        logic      out_rev;
        logic      in_rev;
        crc_mode_e mode;
    } crc_cfg_t;

    function automatic int mode_width(crc_mode_e m);
        int w;
        unique case (m)
            MODE_CRC8:  w = 8;
            MODE_CRC16: w = 16;
            MODE_CCITT: w = 16;
            MODE_CRC32: w = 32;
        endcase
        return w;
    endfunction

    function automatic word_t mode_poly(crc_mode_e m);
        word_t p;
        unique case (m)
            MODE_CRC8:  p = 32'h0000_0007;
            MODE_CRC16: p = 32'h0000_8005;
            MODE_CCITT: p = 32'h0000_1021;
            MODE_CRC32: p = 32'h04C1_1DB7;
        endcase
        return p;
    endfunction

    function automatic word_t mode_mask(crc_mode_e m);
        word_t r;
        int    w;
        w = mode_width(m);
        for (int i = 0; i < CRC_REG_W; i++) begin
            r[i] = (i < w);
        end
        return r;
    endfunction

    function automatic byte_t flip_byte(byte_t b);
        byte_t r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = b[BYTE_W-1-i];
        end
        return r;
    endfunction

    function automatic word_t flip_low(word_t v, int n);
        word_t r;
        r = '0;
        for (int i = 0; i < CRC_REG_W; i++) begin
            if (i < n) begin
                r[i] = v[n-1-i];
            end
        end
        return r;
    endfunction

    // One byte, MSB first, through an N-bit LFSR with implicit top term.
    function automatic word_t crc_byte(word_t state, byte_t b, crc_mode_e m);
        word_t s;
        word_t p;
        word_t msk;
        int    w;
        logic  fb;
        w   = mode_width(m);
        p   = mode_poly(m);
        msk = mode_mask(m);
        s   = state & msk;
        for (int k = BYTE_W - 1; k >= 0; k--) begin
            fb = s[w-1] ^ b[k];
            s  = (s << 1) & msk;
            if (fb) begin
                s = s ^ p;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/mpcrc_cfg_regs.sv
module mpcrc_cfg_regs
    import mpcrc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  reg_sel_e              wr_sel,
    input  logic [CFG_W-1:0]      cfg_wdata,
    input  word_t                 seed_wdata,
    output crc_cfg_t              cfg_q,
    output word_t                 seed_q,
    output logic                  load_pulse,
    output word_t                 load_value
);

    crc_cfg_t cfg_new;
    logic     cfg_we;
    logic     seed_we;

    always_comb begin
        cfg_new.mode    = crc_mode_e'(cfg_wdata[1:0]);
        cfg_new.in_rev  = cfg_wdata[2];
        cfg_new.out_rev = cfg_wdata[3];
        cfg_new.wide    = cfg_wdata[4];
        cfg_we          = wr_en && (wr_sel == REG_CFG);
        seed_we         = wr_en && (wr_sel == REG_SEED);
        load_pulse      = cfg_we && cfg_wdata[CFG_LOAD_BIT];
        load_value      = seed_q & mode_mask(cfg_new.mode);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            seed_q <= '0;
        end else begin
            if (cfg_we) begin
                cfg_q <= cfg_new;
            end
            if (seed_we) begin
                seed_q <= seed_wdata;
            end
        end
    end

    // R3
    seed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == REG_SEED) |=> $stable(seed_q));

endmodule

// File: rtl/mpcrc_seq.sv
module mpcrc_seq
    import mpcrc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      wide,
    input  word_t     data_in,
    output logic      busy,
    output logic      step_en,
    output byte_t     lane_byte
);

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } seq_state_e;

    seq_state_e                state_q;
    seq_state_e                state_d;
    logic [LANE_IDX_W-1:0]     lane_q;
    logic [LANE_IDX_W-1:0]     last_q;
    word_t                     hold_q;
    logic                      last_lane;

    assign last_lane = (lane_q == last_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (last_lane) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
            last_q <= '0;
            hold_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            lane_q <= '0;
            last_q <= wide ? LANE_IDX_W'(LANES - 1) : '0;
            hold_q <= data_in;
        end else if (state_q == ST_SHIFT && !last_lane) begin
            lane_q <= lane_q + 1'b1;
        end
    end

    always_comb begin
        busy      = 1'b0;
        step_en   = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin
                busy    = 1'b0;
                step_en = 1'b0;
            end
            ST_SHIFT: begin
                busy    = 1'b1;
                step_en = 1'b1;
            end
        endcase
        lane_byte = hold_q[lane_q*BYTE_W +: BYTE_W];
    end

    // R4
    lane_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (lane_q <= last_q));

    // R5
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start) |=> busy);

endmodule

// File: rtl/mpcrc_state.sv
module mpcrc_state
    import mpcrc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load,
    input  word_t     load_value,
    input  logic      step,
    input  byte_t     byte_in,
    input  crc_cfg_t  cfg,
    output word_t     sum_out
);

    word_t crc_q;
    word_t crc_next;
    byte_t byte_eff;
    word_t raw;

    always_comb begin
        byte_eff = cfg.in_rev ? flip_byte(byte_in) : byte_in;
        crc_next = crc_byte(crc_q, byte_eff, cfg.mode);
        raw      = crc_q & mode_mask(cfg.mode);
        sum_out  = cfg.out_rev ? flip_low(raw, mode_width(cfg.mode)) : raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (load) begin
            crc_q <= load_value;
        end else if (step) begin
            crc_q <= crc_next;
        end
    end

    // R9
    state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(crc_q));

    // R3
    load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (crc_q == $past(load_value)));

endmodule

// File: rtl/mpcrc_core.sv
module mpcrc_core
    import mpcrc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    output logic        wr_ready,
    input  logic [1:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_addr,
    output logic [31:0] rd_data
);

    logic     accept;
    logic     start;
    logic     busy;
    logic     step_en;
    logic     load_pulse;
    byte_t    lane_byte;
    reg_sel_e wr_sel;
    reg_sel_e rd_sel;
    crc_cfg_t cfg_q;
    word_t    seed_q;
    word_t    load_value;
    word_t    sum_out;

    assign wr_sel   = reg_sel_e'(wr_addr);
    assign rd_sel   = reg_sel_e'(rd_addr);
    assign wr_ready = !busy;
    assign accept   = wr_valid && wr_ready;
    assign start    = accept && (wr_sel == REG_DATA);

    mpcrc_cfg_regs i_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (accept),
        .wr_sel     (wr_sel),
        .cfg_wdata  (wr_data[CFG_W-1:0]),
        .seed_wdata (wr_data),
        .cfg_q      (cfg_q),
        .seed_q     (seed_q),
        .load_pulse (load_pulse),
        .load_value (load_value)
    );

    mpcrc_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wide      (cfg_q.wide),
        .data_in   (wr_data),
        .busy      (busy),
        .step_en   (step_en),
        .lane_byte (lane_byte)
    );

    mpcrc_state i_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_pulse),
        .load_value (load_value),
        .step       (step_en),
        .byte_in    (lane_byte),
        .cfg        (cfg_q),
        .sum_out    (sum_out)
    );

    always_comb begin
        unique case (rd_sel)
            REG_CFG:  rd_data = word_t'(cfg_q);
            REG_SEED: rd_data = seed_q;
            REG_DATA: rd_data = '0;
            REG_SUM:  rd_data = sum_out;
        endcase
    end

    // R5
    byte_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !cfg_q.wide) |-> ##2 wr_ready);

    // R5
    word_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && cfg_q.wide) |-> ##3 !wr_ready);

    // R8
    narrow_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == REG_SUM && cfg_q.mode != MODE_CRC32) |-> (rd_data[31:16] == 16'h0));

    // R8
    crc8_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == REG_SUM && cfg_q.mode == MODE_CRC8) |-> (rd_data[31:8] == 24'h0));

endmodule

// File: tb/test_mpcrc_core.sv
module test_mpcrc_core;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [1:0]  rd_addr = 2'd0;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpcrc_core i_mpcrc_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_ready (wr_ready),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
    endtask

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        wait_idle();
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] d);
        wait_idle();
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // cfg bits: [1:0] mode, 2 in_rev, 3 out_rev, 4 wide, 5 load
    function automatic logic [31:0] cfgw(int mode, bit irev, bit orev, bit wide, bit load);
        return {26'd0, load, wide, orev, irev, mode[1:0]};
    endfunction

    task automatic run_digits(int first, int last);
        for (int b = first; b <= last; b++) begin
            reg_write(2'd2, 32'h30 + b);
        end
    endtask

    task automatic setup(int mode, bit irev, bit orev, logic [31:0] seed);
        reg_write(2'd1, seed);
        reg_write(2'd0, cfgw(mode, irev, orev, 1'b0, 1'b1));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 ready", {31'd0, wr_ready}, 32'd1);
        reg_read(2'd0, v); check("R1 cfg", v, 32'd0);
        reg_read(2'd1, v); check("R1 seed", v, 32'd0);
        reg_read(2'd3, v); check("R1 sum", v, 32'd0);
    endtask

    task automatic t_crc8();
        logic [31:0] v;
        setup(0, 0, 0, 32'h0);
        run_digits(1, 9);
        reg_read(2'd3, v); check("R2 R8 R10 crc8", v, 32'h0000_00F4);
        setup(0, 0, 0, 32'hABCD_EF00);
        run_digits(1, 9);
        reg_read(2'd3, v); check("R3 crc8 seed low bits", v, 32'h0000_00F4);
        reg_read(2'd2, v); check("R2 data reads zero", v, 32'd0);
    endtask

    task automatic t_crc16();
        logic [31:0] v;
        setup(1, 0, 0, 32'h0);
        run_digits(1, 9);
        reg_read(2'd3, v); check("R2 crc16 plain", v, 32'h0000_FEE8);
        setup(1, 1, 1, 32'h0);
        run_digits(1, 9);
        reg_read(2'd3, v); check("R6 R7 crc16 reflected", v, 32'h0000_BB3D);
    endtask

    task automatic t_ccitt();
        logic [31:0] v;
        setup(2, 0, 0, 32'hFFFF_FFFF);
        run_digits(1, 9);
        reg_read(2'd3, v); check("R2 R8 ccitt seed ffff", v, 32'h0000_29B1);
        reg_write(2'd0, cfgw(2, 0, 1, 0, 0));
        reg_read(2'd3, v); check("R7 out_rev only", v, 32'h0000_8D94);
        setup(2, 0, 0, 32'h0);
        run_digits(1, 9);
        reg_read(2'd3, v); check("R2 ccitt seed 0", v, 32'h0000_31C3);
    endtask

    task automatic t_crc32_plain();
        logic [31:0] v;
        setup(3, 0, 0, 32'hFFFF_FFFF);
        run_digits(1, 9);
        reg_read(2'd3, v); check("R2 R10 crc32 plain", v, 32'h0376_E6E7);
    endtask

    task automatic t_mixed_width();
        logic [31:0] v;
        int low;
        setup(3, 1, 1, 32'hFFFF_FFFF);
        reg_write(2'd0, cfgw(3, 1, 1, 1, 0));
        reg_write(2'd2, 32'h3433_3231);
        low = 0;
        while (!wr_ready) begin low++; @(negedge clk); end
        check("R5 word busy cycles", low, 4);
        reg_write(2'd2, 32'h3837_3635);
        reg_write(2'd0, cfgw(3, 1, 1, 0, 0));
        reg_write(2'd2, 32'hFFFF_FF39);
        low = 0;
        while (!wr_ready) begin low++; @(negedge clk); end
        check("R5 byte busy cycles", low, 1);
        reg_read(2'd3, v); check("R4 R6 mixed word/byte crc32", v, 32'h340B_C6D9);
    endtask

    task automatic t_continue();
        logic [31:0] v;
        setup(2, 0, 0, 32'h0000_FFFF);
        run_digits(1, 4);
        reg_read(2'd3, v);
        setup(2, 0, 0, v);
        run_digits(5, 9);
        reg_read(2'd3, v); check("R3 continue from partial", v, 32'h0000_29B1);
    endtask

    task automatic t_ignore();
        logic [31:0] v;
        setup(2, 0, 0, 32'h0000_FFFF);
        run_digits(1, 9);
        reg_write(2'd3, 32'hDEAD_BEEF);
        reg_read(2'd3, v); check("R9 sum write ignored", v, 32'h0000_29B1);
        reg_write(2'd1, 32'h0000_1234);
        reg_write(2'd0, cfgw(2, 0, 0, 1, 0));
        reg_read(2'd3, v); check("R9 cfg no-load keeps state", v, 32'h0000_29B1);
    endtask

    task automatic t_midreset();
        logic [31:0] v;
        setup(3, 0, 0, 32'hFFFF_FFFF);
        reg_write(2'd0, cfgw(3, 0, 0, 1, 0));
        reg_write(2'd2, 32'h1234_5678);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 ready after reset", {31'd0, wr_ready}, 32'd1);
        reg_read(2'd3, v); check("R1 sum after reset", v, 32'd0);
        reg_read(2'd0, v); check("R1 cfg after reset", v, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_crc8();
        t_crc16();
        t_ccitt();
        t_crc32_plain();
        t_mixed_width();
        t_continue();
        t_ignore();
        t_midreset();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule